// File: doc/BRIEF.md
# Delta-Sigma Fractional-N Divide Controller

This block picks the integer divide value that a fractional-N PLL feedback counter uses on each of its cycles. A synthesizer gets a fractional multiplication factor by varying the counter's modulus from cycle to cycle. The controller takes an integer part and a fraction. On every feedback-clock edge it registers a new modulus. Over the long run, the mean of that modulus equals integer + (fraction + 0.5) / 2^FRAC_W. The half step comes from a constant one appended below the fraction's least significant bit. As a result, the accumulator input is never zero and the modulator never settles into a short idle cycle.

The fraction is processed by a third-order cascade of three first-order accumulators (MASH 1-1-1). The carries of the three stages are merged through a difference network into a signed correction between -3 and +4. This pushes quantization error towards high offset frequencies. The sum of integer and correction is clamped to the counter's legal range [DIV_MIN, DIV_MAX].

A two-state machine selects the mode:
- `ST_SHAPE` drives the modulator.
- `ST_BYPASS` outputs the integer part unchanged and freezes the accumulators. This is the low-noise integer-only mode.

The ENGAGE transition (`ST_BYPASS` to `ST_SHAPE`) is taken on an edge where the enable input is high. The RELEASE transition (`ST_SHAPE` to `ST_BYPASS`) is taken on an edge where it is low. Reset enters `ST_BYPASS`.

Top module: `dsm_divctl`

## Requirements
- R1: While reset is asserted, `div_ratio` equals DIV_MIN, the mode is `ST_BYPASS` and all three accumulators hold zero.
- R2: In `ST_BYPASS`, every edge loads `div_ratio` with `int_part` exactly. `frac_part` has no effect on the output.
- R3: `mod_en` is sampled into the mode register on each edge. The new mode governs the value loaded on the following edge, so the edge that performs ENGAGE still loads `int_part`, and the edge that performs RELEASE still loads a modulated value.
- R4: Starting from reset, take the sum of `div_ratio` over the first 2^(FRAC_W+1) modulated edges at a fixed input. This sum equals `int_part`*2^(FRAC_W+1) + 2*`frac_part` + 1, within plus or minus 3. The accumulator input is the fraction with a constant 1 appended as its new LSB.
- R5: When `int_part` lies in [DIV_MIN+3, DIV_MAX-4], each modulated `div_ratio` lies in [`int_part`-3, `int_part`+4].
- R6: Each modulated value is clamped to [DIV_MIN, DIV_MAX]. Both limits are reached when `int_part` sits next to them.
- R7: A change of `int_part` or `frac_part` is used from the next edge on, in either mode. Such a change does not clear the accumulators, so the R4 sum still holds across a change of `int_part`.
- R8: The accumulators and the carry delay stages hold their values while in `ST_BYPASS`. After a later ENGAGE they resume from those values, and the total over the modulated edges still meets R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback clock; one edge per counter cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | 1 selects fractional operation, 0 selects integer-only |
| int_part | input | INT_W | Integer part of the divide factor |
| frac_part | input | FRAC_W | Fraction, weight 2^-FRAC_W per LSB |
| div_ratio | output | INT_W | Registered modulus for the next counter cycle |

## Verification
The bench builds the controller with FRAC_W = 10. This shortens the accumulators to 11 bits, so a whole accumulator period is 2048 edges. The exact long-run sum can therefore be checked for several fractions, including 0 and all-ones, and across a mid-run change and a bypass pause. DIV_MIN is raised to 8, so a low integer part can drive the correction into the lower clamp. INT_W stays 7 with DIV_MAX = 127, so a missing upper clamp would show up as a wrap to small values.

// File: rtl/divctl_pkg.sv
`timescale 1ns/1ps
package divctl_pkg;

    // Number of cascaded first-order stages (MASH 1-1-1).
    localparam int MASH_ORDER = 3;

    // Width of the merged correction term (range -3 .. +4).
    localparam int CORR_W = 4;

    typedef logic signed [CORR_W-1:0] corr_t;

    typedef enum logic {
        ST_BYPASS = 1'b0,
        ST_SHAPE  = 1'b1
    } mode_e;

endpackage

// File: rtl/dsm_acc_stage.sv
`timescale 1ns/1ps
// One first-order accumulator stage: exposes its next sum and the carry out.
module dsm_acc_stage #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] sum_nxt,
    output logic         carry
);

    always_comb begin
        {carry, sum_nxt} = {1'b0, acc_q} + {1'b0, addend};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum_nxt;
        end
    end

endmodule

// File: rtl/dsm_noise_combine.sv
`timescale 1ns/1ps
// Merges the three stage carries: c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3.
module dsm_noise_combine
    import divctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [MASH_ORDER-1:0] carry_in,
    output corr_t                 corr
);

    logic c2_d;
    logic c3_d;
    logic c3_dd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (step) begin
            c2_d  <= carry_in[1];
            c3_d  <= carry_in[2];
            c3_dd <= c3_d;
        end
    end

    always_comb begin
        corr = $signed({3'b000, carry_in[0]})
             + $signed({3'b000, carry_in[1]})
             - $signed({3'b000, c2_d})
             + $signed({3'b000, carry_in[2]})
             - $signed({2'b00, c3_d, 1'b0})
             + $signed({3'b000, c3_dd});
    end

endmodule

// File: rtl/dsm_divctl.sv
`timescale 1ns/1ps
// Fractional-N divide controller: mode FSM, MASH 1-1-1 cascade and clamp.
module dsm_divctl
    import divctl_pkg::*;
#(
    parameter int INT_W   = 7,
    parameter int FRAC_W  = 18,
    parameter int DIV_MIN = 4,
    parameter int DIV_MAX = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic [INT_W-1:0]  int_part,
    input  logic [FRAC_W-1:0] frac_part,
    output logic [INT_W-1:0]  div_ratio
);

    localparam int ACC_W = FRAC_W + 1;
    localparam int WIDE  = INT_W + 2;
    localparam logic signed [WIDE-1:0] LO_S = WIDE'(DIV_MIN);
    localparam logic signed [WIDE-1:0] HI_S = WIDE'(DIV_MAX);

    mode_e mode_q;
    mode_e mode_d;
    logic  step;

    logic [ACC_W-1:0]      stage_in [MASH_ORDER];
    logic [ACC_W-1:0]      sum_nxt  [MASH_ORDER];
    logic [ACC_W-1:0]      acc_q    [MASH_ORDER];
    logic [MASH_ORDER-1:0] carry;

    corr_t                 corr;
    logic signed [WIDE-1:0] raw_sum;
    logic [INT_W-1:0]      shaped;
    logic [INT_W-1:0]      ratio_d;

    // ---------------- mode state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= ST_BYPASS;
        end else begin
            mode_q <= mode_d;
        end
    end

    // ---------------- transitions (ENGAGE / RELEASE) ----------------
    always_comb begin
        unique case (mode_q)
            ST_BYPASS: mode_d = mod_en ? ST_SHAPE  : ST_BYPASS;
            ST_SHAPE:  mode_d = mod_en ? ST_SHAPE  : ST_BYPASS;
            default:   mode_d = ST_BYPASS;
        endcase
    end

    assign step = (mode_q == ST_SHAPE);

    // ---------------- accumulator cascade ----------------
    for (genvar g = 0; g < MASH_ORDER; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_in[g] = {frac_part, 1'b1};
        end else begin : g_tail
            assign stage_in[g] = sum_nxt[g-1];
        end

        dsm_acc_stage #(
            .W (ACC_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .addend  (stage_in[g]),
            .acc_q   (acc_q[g]),
            .sum_nxt (sum_nxt[g]),
            .carry   (carry[g])
        );
    end

    dsm_noise_combine u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .carry_in (carry),
        .corr     (corr)
    );

    // ---------------- clamp ----------------
    always_comb begin
        raw_sum = $signed({2'b00, int_part}) + WIDE'(corr);
        if (raw_sum < LO_S) begin
            shaped = INT_W'(DIV_MIN);
        end else if (raw_sum > HI_S) begin
            shaped = INT_W'(DIV_MAX);
        end else begin
            shaped = INT_W'(raw_sum);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (mode_q)
            ST_BYPASS: ratio_d = int_part;
            ST_SHAPE:  ratio_d = shaped;
            default:   ratio_d = int_part;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_ratio <= INT_W'(DIV_MIN);
        end else begin
            div_ratio <= ratio_d;
        end
    end

endmodule

// File: rtl/dsm_divctl_chk.sv
`timescale 1ns/1ps
module dsm_divctl_chk
    import divctl_pkg::*;
#(
    parameter int INT_W   = 7,
    parameter int ACC_W   = 19,
    parameter int DIV_MIN = 4,
    parameter int DIV_MAX = 127
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic [INT_W-1:0] int_part,
    input logic [INT_W-1:0] div_ratio,
    input mode_e            mode_q,
    input logic [ACC_W-1:0] acc_first,
    input logic [ACC_W-1:0] acc_last
);

    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mod_en) |=> div_ratio == $past(int_part)); // R2

    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == ST_SHAPE |=> (int'(div_ratio) >= DIV_MIN) && (int'(div_ratio) <= DIV_MAX)); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SHAPE && int'(int_part) >= DIV_MIN + 3 && int'(int_part) + 4 <= DIV_MAX)
        |=> (int'(div_ratio) + 3 >= int'($past(int_part))) && (int'(div_ratio) <= int'($past(int_part)) + 4)); // R5

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == ST_BYPASS |=> $stable(acc_first) && $stable(acc_last)); // R8

endmodule

bind dsm_divctl dsm_divctl_chk #(
    .INT_W   (INT_W),
    .ACC_W   (FRAC_W + 1),
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .int_part  (int_part),
    .div_ratio (div_ratio),
    .mode_q    (mode_q),
    .acc_first (acc_q[0]),
    .acc_last  (acc_q[2])
);

// File: tb/tb_dsm_divctl.sv
`timescale 1ns/1ps
module tb_dsm_divctl;

    localparam int INT_W   = 7;
    localparam int FRAC_W  = 10;
    localparam int DIV_MIN = 8;
    localparam int DIV_MAX = 127;
    localparam int N       = 1 << (FRAC_W + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mod_en = 1'b0;
    logic [INT_W-1:0]  int_part = '0;
    logic [FRAC_W-1:0] frac_part = '0;
    logic [INT_W-1:0]  div_ratio;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dsm_divctl #(
        .INT_W   (INT_W),
        .FRAC_W  (FRAC_W),
        .DIV_MIN (DIV_MIN),
        .DIV_MAX (DIV_MAX)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_en    (mod_en),
        .int_part  (int_part),
        .frac_part (frac_part),
        .div_ratio (div_ratio)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Reset with given inputs, then one edge (still integer-only mode).
    task automatic do_reset(input int mint, input int frac, input bit en);
        rst_n     = 1'b0;
        int_part  = INT_W'(mint);
        frac_part = FRAC_W'(frac);
        mod_en    = en;
        tick();
        tick();
        check(div_ratio == INT_W'(DIV_MIN), "R1", "output held in reset", div_ratio, DIV_MIN);
        rst_n = 1'b1;
        tick();
        check(div_ratio == INT_W'(mint), "R3", "first edge after reset loads integer", div_ratio, mint);
    endtask

    task automatic test_bypass();
        bit ok = 1'b1;
        int bad = 0;
        do_reset(50, 300, 1'b0);
        for (int i = 0; i < 6; i++) begin
            frac_part = FRAC_W'(i * 97 + 5);
            tick();
            if (div_ratio != 7'd50) begin
                ok = 1'b0;
                bad = div_ratio;
            end
        end
        check(ok, "R2", "bypass output equals integer, fraction ignored", bad, 50);
        int_part = 7'd20;
        tick();
        check(div_ratio == 7'd20, "R7", "integer change used at next edge", div_ratio, 20);
        int_part = 7'd90;
        tick();
        check(div_ratio == 7'd90, "R7", "second integer change used at next edge", div_ratio, 90);
    endtask

    task automatic test_average(input int mint, input int frac);
        longint sum = 0;
        longint expv;
        bit dev_ok = 1'b1;
        int dev_val = mint;
        do_reset(mint, frac, 1'b1);
        for (int i = 0; i < N; i++) begin
            tick();
            sum += div_ratio;
            if (int'(div_ratio) < mint - 3 || int'(div_ratio) > mint + 4) begin
                dev_ok = 1'b0;
                dev_val = div_ratio;
            end
        end
        expv = longint'(mint) * N + 2 * frac + 1;
        check(sum >= expv - 3 && sum <= expv + 3, "R4", "period sum", sum, expv);
        check(dev_ok, "R5", "per-edge deviation within -3..+4", dev_val, mint);
    endtask

    task automatic test_hold();
        longint sum = 0;
        longint expv;
        int cnt = 0;
        bit ok = 1'b1;
        int bad = 0;
        do_reset(60, 700, 1'b1);
        while (cnt < N / 2) begin
            tick();
            sum += div_ratio;
            cnt++;
        end
        mod_en = 1'b0;
        tick();               // RELEASE edge: still modulated
        sum += div_ratio;
        cnt++;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (div_ratio != 7'd60) begin
                ok = 1'b0;
                bad = div_ratio;
            end
        end
        check(ok, "R3", "integer-only after release latency", bad, 60);
        mod_en = 1'b1;
        tick();               // ENGAGE edge: still integer
        check(div_ratio == 7'd60, "R3", "engage edge loads integer", div_ratio, 60);
        while (cnt < N) begin
            tick();
            sum += div_ratio;
            cnt++;
        end
        expv = 60 * longint'(N) + 2 * 700 + 1;
        check(sum >= expv - 3 && sum <= expv + 3, "R8", "sum across bypass pause", sum, expv);
    endtask

    task automatic test_int_change();
        longint sum = 0;
        longint expv;
        do_reset(40, 455, 1'b1);
        for (int i = 0; i < N / 2; i++) begin
            tick();
            sum += div_ratio;
        end
        int_part = 7'd41;
        tick();
        sum += div_ratio;
        check(int'(div_ratio) >= 38 && int'(div_ratio) <= 45, "R7", "new integer used next edge", div_ratio, 41);
        for (int i = N / 2 + 1; i < N; i++) begin
            tick();
            sum += div_ratio;
        end
        expv = 40 * longint'(N / 2) + 41 * longint'(N / 2) + 2 * 455 + 1;
        check(sum >= expv - 3 && sum <= expv + 3, "R7", "sum across integer change, no clear", sum, expv);
    endtask

    task automatic test_clamp(input int mint);
        int mn = 1000;
        int mx = -1;
        do_reset(mint, 512, 1'b1);
        for (int i = 0; i < N; i++) begin
            tick();
            if (int'(div_ratio) < mn) mn = div_ratio;
            if (int'(div_ratio) > mx) mx = div_ratio;
        end
        if (mint == DIV_MIN) begin
            check(mn == DIV_MIN, "R6", "lower clamp reached", mn, DIV_MIN);
            check(mx <= DIV_MIN + 4, "R6", "upper bound near low limit", mx, DIV_MIN + 4);
        end else begin
            check(mx == DIV_MAX, "R6", "upper clamp reached", mx, DIV_MAX);
            check(mn >= mint - 3, "R6", "no wrap near high limit", mn, mint - 3);
        end
    endtask

    initial begin
        test_bypass();
        test_average(40, 0);
        test_average(40, 517);
        test_average(40, 1023);
        test_average(100, 341);
        test_hold();
        test_int_change();
        test_clamp(DIV_MIN);
        test_clamp(DIV_MAX - 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule